// File: doc/BRIEF.md
# Dual-Bank Entity State Store with Link Change Detection

This block keeps the per-entity storage of a time-multiplexed simulator. In such a simulator many copies of one component are evaluated one after another on a single shared evaluation cell. Each copy, called an entity, owns two things, both addressed by an entity index:

- a state vector, which holds its internal storage;
- a link vector, which holds its outputs.

Together these form the entity vector.

State is kept in two equal banks. One bank is read as the frozen "previous" state. The other bank receives the state that each evaluation produces. An entity may be evaluated several times in one system cycle while links settle, and its previous state must not move during that time. When the scheduler decides that no link is changing any more, it pulses a swap. The bank that was being written then becomes the bank that is read. Link vectors sit in one unswapped memory.

When an evaluation writes back a link vector, the block compares it with the stored copy. One cycle later it pulses a flag if the two differ, so that the scheduler can queue the entities that depend on that link for another evaluation.

Top module: `ent_state_store`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `bank_sel` is 0, `rd_valid` and `link_chg` are 0, and every entity later reads back zero state and zero link until it is written.
- R2: A read presented with `rd_en` at one edge yields `rd_valid`=1 together with `old_state` and `old_link` for `rd_idx` after that edge. An edge without `rd_en` leaves `rd_valid`=0.
- R3: A write of `new_state` goes only to the bank not selected by `bank_sel`. The state read for any entity stays unchanged across any number of writes until a swap.
- R4: `swap` at an edge inverts `bank_sel`. After the swap, `old_state` for each entity returns the value last written to it before the swap.
- R5: A write issued in the same cycle as `swap` lands in the bank that was the write bank before the swap, so it is visible as old state right after the swap.
- R6: The link memory is not swapped. After a write, `old_link` for that entity returns the latest `new_link`.
- R7: `link_chg` is 1 for exactly the cycle after a write whose `new_link` differs from the stored link of `wr_idx`. It is 0 after a write of an equal link and after any cycle without a write.
- R8: A read and a write to the same entity in the same cycle return the link stored before that write and the state of the old bank.
- R9: Two swaps with no writes in between restore `bank_sel` and the old-state contents that were read before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request for one entity |
| rd_idx | input | IDX_W | Entity to read |
| wr_en | input | 1 | Write-back of one evaluation |
| wr_idx | input | IDX_W | Entity written |
| new_state | input | STATE_W | Freshly computed state |
| new_link | input | LINK_W | Freshly computed link vector |
| swap | input | 1 | End of system cycle: exchange bank roles |
| rd_valid | output | 1 | Read data valid |
| old_state | output | STATE_W | Previous state of the read entity |
| old_link | output | LINK_W | Stored link vector of the read entity |
| link_chg | output | 1 | Last write changed its link vector |
| bank_sel | output | 1 | Bank currently holding previous state |

## Verification
The assertions assume three things about the inputs: `rd_idx` and `wr_idx` stay below the entity count, reset is released away from a clock edge, and `swap` is a plain pulse that the scheduler raises only once all links have settled. The bench keeps every index inside the configured range and changes all inputs on the falling clock edge. It issues swaps only at the points of its own reference schedule, including one that coincides with a write. It also sweeps every entity in each phase of that schedule.

// File: rtl/ess_pkg.sv
package ess_pkg;
   // Role of a state bank within one system cycle.
   typedef enum logic {
      BANK_ZERO = 1'b0,
      BANK_ONE  = 1'b1
   } ess_bank_e;

   function automatic ess_bank_e ess_other(input ess_bank_e b);
      return (b == BANK_ZERO) ? BANK_ONE : BANK_ZERO;
   endfunction
endpackage

// File: rtl/ess_mem.sv
// One state bank: synchronous read, one write port, cleared on reset.
module ess_mem #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             we,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
         rd_data <= '0;
      end else begin
         if (rd_en) rd_data <= cells[rd_addr];
         if (we)    cells[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/ess_link_mem.sv
// Link memory with write-back comparison; reads return pre-write data.
module ess_link_mem #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             we,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   output logic             differs
);
   logic [WIDTH-1:0] cells [DEPTH];
   logic [WIDTH-1:0] stored_at_wr;

   assign stored_at_wr = cells[wr_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
         rd_data <= '0;
         differs <= 1'b0;
      end else begin
         if (rd_en) rd_data <= cells[rd_addr];
         if (we)    cells[wr_addr] <= wr_data;
         differs <= we && (wr_data != stored_at_wr);
      end
   end
endmodule

// File: rtl/ess_bank_ctrl.sv
// Tracks which bank holds previous state; flips on swap.
module ess_bank_ctrl
   import ess_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      swap,
   output ess_bank_e old_bank
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    old_bank <= BANK_ZERO;
      else if (swap) old_bank <= ess_other(old_bank);
   end
endmodule

// File: rtl/ent_state_store.sv
module ent_state_store
   import ess_pkg::*;
#(
   parameter int N_ENT   = 16,
   parameter int STATE_W = 32,
   parameter int LINK_W  = 16,
   localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_idx,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [STATE_W-1:0] new_state,
   input  logic [LINK_W-1:0]  new_link,
   input  logic               swap,
   output logic               rd_valid,
   output logic [STATE_W-1:0] old_state,
   output logic [LINK_W-1:0]  old_link,
   output logic               link_chg,
   output logic               bank_sel
);
   localparam int N_BANK = 2;

   if (N_ENT < 2)   begin : g_bad_ent   $error("N_ENT must be at least 2"); end
   if (STATE_W < 1) begin : g_bad_state $error("STATE_W must be positive"); end
   if (LINK_W < 1)  begin : g_bad_link  $error("LINK_W must be positive");  end

   ess_bank_e              old_bank;
   ess_bank_e              rd_bank_q;
   logic [STATE_W-1:0]     bank_rd [N_BANK];

   ess_bank_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .swap     (swap),
      .old_bank (old_bank)
   );

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      logic bank_we;
      // Only the bank not holding previous state accepts writes.
      assign bank_we = wr_en && (old_bank != ess_bank_e'(b));
      ess_mem #(.WIDTH(STATE_W), .DEPTH(N_ENT)) u_mem (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_en   (rd_en),
         .rd_addr (rd_idx),
         .rd_data (bank_rd[b]),
         .we      (bank_we),
         .wr_addr (wr_idx),
         .wr_data (new_state)
      );
   end

   ess_link_mem #(.WIDTH(LINK_W), .DEPTH(N_ENT)) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_idx),
      .rd_data (old_link),
      .we      (wr_en),
      .wr_addr (wr_idx),
      .wr_data (new_link),
      .differs (link_chg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_bank_q <= BANK_ZERO;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_bank_q <= old_bank;
      end
   end

   assign old_state = (rd_bank_q == BANK_ONE) ? bank_rd[1] : bank_rd[0];
   assign bank_sel  = old_bank;
endmodule

// File: rtl/ess_store_chk.sv
module ess_store_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_en,
   input logic wr_en,
   input logic swap,
   input logic rd_valid,
   input logic link_chg,
   input logic bank_sel
);
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!bank_sel && !rd_valid && !link_chg));

   a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r2_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   a_r4_swap_flips: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (bank_sel != $past(bank_sel)));

   a_r4_hold_bank: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> $stable(bank_sel));

   a_r7_flag_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !link_chg);
endmodule

bind ent_state_store ess_store_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .swap     (swap),
   .rd_valid (rd_valid),
   .link_chg (link_chg),
   .bank_sel (bank_sel)
);

// File: tb/tb_ent_state_store.sv
module tb_ent_state_store;
   localparam int NE = 8;
   localparam int SW = 16;
   localparam int LW = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0, wr_en = 1'b0, swap = 1'b0;
   logic [IW-1:0] rd_idx = '0, wr_idx = '0;
   logic [SW-1:0] new_state = '0;
   logic [LW-1:0] new_link = '0;
   logic          rd_valid, link_chg, bank_sel;
   logic [SW-1:0] old_state;
   logic [LW-1:0] old_link;

   int checks = 0;
   int errors = 0;

   // Reference model
   logic [SW-1:0] m_bank [2][NE];
   logic [LW-1:0] m_link [NE];
   int            m_sel = 0;

   always #4 clk = ~clk;

   ent_state_store #(.N_ENT(NE), .STATE_W(SW), .LINK_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .new_state(new_state),
      .new_link(new_link), .swap(swap), .rd_valid(rd_valid),
      .old_state(old_state), .old_link(old_link),
      .link_chg(link_chg), .bank_sel(bank_sel)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, update model, sample at next negedge.
   task automatic cyc(input bit rd, input int ri, input bit wr, input int wi,
                      input logic [SW-1:0] ns, input logic [LW-1:0] nl,
                      input bit sw, input string req);
      logic [SW-1:0] e_st;
      logic [LW-1:0] e_ln;
      bit            e_chg;
      rd_en = rd; rd_idx = IW'(ri); wr_en = wr; wr_idx = IW'(wi);
      new_state = ns; new_link = nl; swap = sw;
      e_st  = m_bank[m_sel][ri];
      e_ln  = m_link[ri];
      e_chg = wr && (nl != m_link[wi]);
      if (wr) begin
         m_bank[1 - m_sel][wi] = ns;
         m_link[wi] = nl;
      end
      if (sw) m_sel = 1 - m_sel;
      @(posedge clk);
      @(negedge clk);
      check({req, " rd_valid (R2)"}, 32'(rd_valid), 32'(rd));
      if (rd) begin
         check({req, " old_state"}, 32'(old_state), 32'(e_st));
         check({req, " old_link"},  32'(old_link),  32'(e_ln));
      end
      check({req, " link_chg (R7)"}, 32'(link_chg), 32'(e_chg));
      check({req, " bank_sel (R4)"}, 32'(bank_sel), 32'(m_sel));
      rd_en = 0; wr_en = 0; swap = 0;
   endtask

   function automatic logic [SW-1:0] st_val(input int e, input int p);
      return SW'(e * 37 + p * 1000 + 5);
   endfunction

   function automatic logic [LW-1:0] ln_val(input int e, input int p);
      return LW'(e * 5 + p * 3 + 1);
   endfunction

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] snap [NE];
      for (int e = 0; e < NE; e++) begin
         m_bank[0][e] = '0; m_bank[1][e] = '0; m_link[e] = '0;
      end
      repeat (3) @(negedge clk);
      check("R1 bank_sel in reset", 32'(bank_sel), 0);
      check("R1 rd_valid in reset", 32'(rd_valid), 0);
      check("R1 link_chg in reset", 32'(link_chg), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 bank_sel after reset", 32'(bank_sel), 0);
      // R1, R2: every entity reads zero
      for (int e = 0; e < NE; e++) cyc(1, e, 0, 0, '0, '0, 0, "R1 zero read");
      cyc(0, 0, 0, 0, '0, '0, 0, "R2 idle");
      // R3, R7: first write pass; every link changes
      for (int e = 0; e < NE; e++) cyc(0, 0, 1, e, st_val(e, 1), ln_val(e, 1), 0, "R7 pass1 write");
      // R3: old state still zero, R6: links updated
      for (int e = 0; e < NE; e++) cyc(1, e, 0, 0, '0, '0, 0, "R3 R6 read before swap");
      // R3: repeated evaluation of entity 3 does not move its old state
      cyc(0, 0, 1, 3, st_val(3, 9), ln_val(3, 9), 0, "R3 re-eval");
      cyc(1, 3, 0, 0, '0, '0, 0, "R3 old held");
      // R7: equal link gives no flag
      cyc(0, 0, 1, 5, st_val(5, 2), ln_val(5, 1), 0, "R7 same link");
      // R5: write together with swap
      cyc(0, 0, 1, 7, st_val(7, 4), ln_val(7, 4), 1, "R5 write with swap");
      // R4, R5: old state is what was written
      for (int e = 0; e < NE; e++) cyc(1, e, 0, 0, '0, '0, 0, "R4 R5 read after swap");
      // R8: read and write same entity in one cycle
      for (int e = 0; e < NE; e++) cyc(1, e, 1, e, st_val(e, 6), ln_val(e, 6), 0, "R8 same entity");
      for (int e = 0; e < NE; e++) cyc(1, e, 0, 0, '0, '0, 0, "R6 read");
      // R9: double swap restores view
      for (int e = 0; e < NE; e++) snap[e] = 32'(m_bank[m_sel][e]);
      cyc(0, 0, 0, 0, '0, '0, 1, "R9 swap a");
      cyc(0, 0, 0, 0, '0, '0, 1, "R9 swap b");
      for (int e = 0; e < NE; e++) begin
         cyc(1, e, 0, 0, '0, '0, 0, "R9 read back");
         check("R9 restored state", 32'(old_state), snap[e]);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule